// File: doc/BRIEF.md
# Floating-Point Multiplier with Exception Flags

This block multiplies two packed binary floating-point operands of a parameterised format and returns the packed product together with five exception indications: invalid operation, divide by zero, overflow, underflow and inexact. The exponent width and the significand width (hidden bit counted) are parameters. The defaults of 8 and 24 give a 32-bit single-precision word. Each operand is sorted into a class: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. The signalling test reads the raw stored fraction, because a decoded value does not keep that information.

Finite nonzero operands take the arithmetic path. The full-width significand product is normalised, denormalised when it is tiny, and rounded to nearest with ties to even using guard, round and sticky bits. It is then repacked. A carry out of rounding moves the result into the next binade and can by itself cause overflow to infinity. The special-case logic overrides the arithmetic path for NaN, infinity and zero operands. Product and flags are registered, so a result appears one clock after its operands. The flags describe that single operation only and are not accumulated.

Top module: `fp_mul_exc`

## Requirements
- R1: Product and flags are registered: operands applied before a rising clock edge show at the outputs after that edge. While rst_n is low, the product and all five flags read zero.
- R2: For finite nonzero operands, the product is the exact product rounded to nearest with ties to even. Its sign is the XOR of the operand signs.
- R3: A NaN operand (exponent all ones, fraction nonzero) is signalling when stored fraction bit SIG_W-2 is zero. If either operand is signalling, exc_invalid is set and the product is the canonical quiet NaN. The canonical quiet NaN has sign 0, exponent all ones, fraction MSB 1 and the other fraction bits 0 (0x7FC00000 by default).
- R4: Infinity times zero, in either order, sets exc_invalid and returns the canonical quiet NaN. Whenever exc_invalid is set, the product is a NaN.
- R5: A quiet NaN operand with no signalling NaN present returns the canonical quiet NaN and sets no flag.
- R6: When the rounded exponent reaches all ones, the product is an infinity with the XOR sign, and exc_overflow and exc_inexact are set. The largest finite value times one is exact and raises no flag.
- R7: exc_underflow is set only when the result is inexact and the rounded result has a zero exponent field (subnormal or zero). An exact subnormal result, or a tiny value that rounds up to the smallest normal, leaves it clear.
- R8: exc_inexact is set whenever rounding discards nonzero bits, and is always set when exc_overflow or exc_underflow is set.
- R9: exc_divzero is never set by this operation.
- R10: Infinity times a finite nonzero value gives an infinity with the XOR sign and no flags. A zero times a finite value gives a zero with the XOR sign and no flags.
- R11: A rounding increment that carries out of the significand gives a fraction of zero and adds one to the exponent, up to and including overflow to infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | EXP_W+SIG_W | First packed operand |
| op_b | input | EXP_W+SIG_W | Second packed operand |
| prod | output | EXP_W+SIG_W | Registered packed product |
| exc_invalid | output | 1 | Invalid operation for the registered product |
| exc_divzero | output | 1 | Divide by zero (always 0 for multiplication) |
| exc_overflow | output | 1 | Overflow to infinity |
| exc_underflow | output | 1 | Inexact tiny result |
| exc_inexact | output | 1 | Rounded result differs from exact product |

## Verification
The properties assume that op_a and op_b hold known values at every rising edge after reset is released. They also assume that the flags seen one clock later belong to the operands sampled at the previous edge, so each operand pair must be steady around its sampling edge. The bench releases reset and changes operands only on falling clock edges, which keeps every operand pair stable for a full half period on both sides of the edge that captures it. The flag-consistency properties (invalid with NaN, overflow with infinity, underflow with a zero exponent field, overflow or underflow with inexact) are then checked on every registered result the table and directed tests produce.

// File: rtl/fp_mul_pkg.sv
package fp_mul_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } fp_cls_e;

    typedef struct packed {
        logic invalid;
        logic divzero;
        logic overflow;
        logic underflow;
        logic inexact;
    } fp_exc_t;

endpackage

// File: rtl/fp_mul_unpack.sv
module fp_mul_unpack
    import fp_mul_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input  logic [EXP_W+SIG_W-1:0] op,
    output logic                   sign,
    output fp_cls_e                cls,
    output logic [SIG_W-1:0]       sig,
    output logic [EXP_W-1:0]       exp_eff
);
    localparam int W      = EXP_W + SIG_W;
    localparam int FRAC_W = SIG_W - 1;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac;
    logic              exp_max;
    logic              exp_zero;
    logic              frac_nz;

    always_comb begin
        sign     = op[W-1];
        exp_f    = op[W-2 -: EXP_W];
        frac     = op[FRAC_W-1:0];
        exp_max  = &exp_f;
        exp_zero = ~|exp_f;
        frac_nz  = |frac;
        if (exp_max) begin
            if (!frac_nz)               cls = CLS_INF;
            else if (frac[FRAC_W-1])    cls = CLS_QNAN;
            else                        cls = CLS_SNAN;
        end else if (exp_zero) begin
            cls = frac_nz ? CLS_SUB : CLS_ZERO;
        end else begin
            cls = CLS_NORM;
        end
        // Hidden bit is one only for normal encodings; subnormals use exponent 1.
        sig     = {~exp_zero, frac};
        exp_eff = exp_zero ? EXP_W'(1) : exp_f;
    end

endmodule

// File: rtl/fp_mul_core.sv
module fp_mul_core
    import fp_mul_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input  logic                   sign,
    input  logic [SIG_W-1:0]       sig_a,
    input  logic [SIG_W-1:0]       sig_b,
    input  logic [EXP_W-1:0]       exp_a,
    input  logic [EXP_W-1:0]       exp_b,
    output logic [EXP_W+SIG_W-1:0] val,
    output fp_exc_t                exc
);
    localparam int P      = 2 * SIG_W;
    localparam int FRAC_W = SIG_W - 1;
    localparam int XW     = EXP_W + $clog2(P) + 3;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;

    logic [P-1:0]           prod_w;
    int                     lead;
    logic [P-1:0]           norm;
    logic signed [XW-1:0]   re;
    int                     rsh;
    logic [XW-1:0]          e_enc;
    logic [2*P-1:0]         ext;
    logic [SIG_W-1:0]       mant;
    logic                   g_bit, r_bit, s_bit, inc, lost;
    logic [XW+FRAC_W-1:0]   sum;
    logic [XW-1:0]          e_out;
    logic                   ovf;

    always_comb begin
        prod_w = {{SIG_W{1'b0}}, sig_a} * {{SIG_W{1'b0}}, sig_b};

        lead = 0;
        for (int i = 0; i < P; i++) begin
            if (prod_w[i]) lead = i;
        end
        norm = prod_w << (P - 1 - lead);

        // Biased exponent of the value 1.f with the leading one at position lead.
        re = XW'(lead) - XW'(2 * FRAC_W) + XW'(exp_a) + XW'(exp_b) - XW'(BIAS);

        if (re < 1) begin
            rsh = 1 - int'(re);
            if (rsh > P + 1) rsh = P + 1;
            e_enc = '0;
        end else begin
            rsh   = 0;
            e_enc = re;
        end

        ext   = {norm, {P{1'b0}}} >> rsh;
        mant  = ext[2*P-1 -: SIG_W];
        g_bit = ext[2*P-1-SIG_W];
        r_bit = ext[2*P-2-SIG_W];
        s_bit = |ext[2*P-3-SIG_W:0];
        lost  = g_bit | r_bit | s_bit;
        inc   = g_bit & (r_bit | s_bit | mant[0]);

        // Exponent and fraction side by side: a fraction carry bumps the exponent.
        sum   = {e_enc, mant[FRAC_W-1:0]} + (XW+FRAC_W)'(inc);
        e_out = sum[XW+FRAC_W-1 -: XW];
        ovf   = (e_out >= XW'(EMAX));

        exc           = '0;
        exc.overflow  = ovf;
        exc.inexact   = lost | ovf;
        exc.underflow = ~ovf & lost & (e_out == '0);
        if (ovf) val = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else     val = {sign, e_out[EXP_W-1:0], sum[FRAC_W-1:0]};
    end

endmodule

// File: rtl/fp_mul_exc.sv
module fp_mul_exc
    import fp_mul_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [EXP_W+SIG_W-1:0] op_a,
    input  logic [EXP_W+SIG_W-1:0] op_b,
    output logic [EXP_W+SIG_W-1:0] prod,
    output logic                   exc_invalid,
    output logic                   exc_divzero,
    output logic                   exc_overflow,
    output logic                   exc_underflow,
    output logic                   exc_inexact
);
    localparam int W      = EXP_W + SIG_W;
    localparam int FRAC_W = SIG_W - 1;
    localparam logic [W-1:0] QNAN_C = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic [W-1:0] val;
        fp_exc_t      exc;
    } res_t;

    logic [W-1:0]     ops     [2];
    logic [1:0]       sgn;
    fp_cls_e          cls     [2];
    logic [SIG_W-1:0] sig     [2];
    logic [EXP_W-1:0] exp_eff [2];
    logic [W-1:0]     core_val;
    fp_exc_t          core_exc;
    logic             res_sign;
    logic             any_nan, any_snan, any_inf, any_zero;
    res_t             res_d, res_q;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar k = 0; k < 2; k++) begin : g_unpack
        fp_mul_unpack #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_unpack (
            .op      (ops[k]),
            .sign    (sgn[k]),
            .cls     (cls[k]),
            .sig     (sig[k]),
            .exp_eff (exp_eff[k])
        );
    end

    assign res_sign = sgn[0] ^ sgn[1];

    fp_mul_core #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_core (
        .sign  (res_sign),
        .sig_a (sig[0]),
        .sig_b (sig[1]),
        .exp_a (exp_eff[0]),
        .exp_b (exp_eff[1]),
        .val   (core_val),
        .exc   (core_exc)
    );

    always_comb begin
        any_snan = (cls[0] == CLS_SNAN) | (cls[1] == CLS_SNAN);
        any_nan  = any_snan | (cls[0] == CLS_QNAN) | (cls[1] == CLS_QNAN);
        any_inf  = (cls[0] == CLS_INF)  | (cls[1] == CLS_INF);
        any_zero = (cls[0] == CLS_ZERO) | (cls[1] == CLS_ZERO);

        res_d.val = core_val;
        res_d.exc = core_exc;
        if (any_nan) begin
            res_d.val         = QNAN_C;
            res_d.exc         = '0;
            res_d.exc.invalid = any_snan;
        end else if (any_inf && any_zero) begin
            res_d.val         = QNAN_C;
            res_d.exc         = '0;
            res_d.exc.invalid = 1'b1;
        end else if (any_inf) begin
            res_d.val = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            res_d.exc = '0;
        end else if (any_zero) begin
            res_d.val = {res_sign, {(W-1){1'b0}}};
            res_d.exc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign prod          = res_q.val;
    assign exc_invalid   = res_q.exc.invalid;
    assign exc_divzero   = res_q.exc.divzero;
    assign exc_overflow  = res_q.exc.overflow;
    assign exc_underflow = res_q.exc.underflow;
    assign exc_inexact   = res_q.exc.inexact;

endmodule

// File: rtl/fp_mul_exc_chk.sv
module fp_mul_exc_chk #(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [EXP_W+SIG_W-1:0] op_a,
    input logic [EXP_W+SIG_W-1:0] op_b,
    input logic [EXP_W+SIG_W-1:0] prod,
    input logic                   exc_invalid,
    input logic                   exc_divzero,
    input logic                   exc_overflow,
    input logic                   exc_underflow,
    input logic                   exc_inexact
);
    localparam int W      = EXP_W + SIG_W;
    localparam int FRAC_W = SIG_W - 1;

    logic a_sig_nan, b_sig_nan, a_quiet, b_quiet;
    logic p_nan, p_inf, p_expz;

    assign a_sig_nan = (&op_a[W-2 -: EXP_W]) & (|op_a[FRAC_W-1:0]) & ~op_a[FRAC_W-1];
    assign b_sig_nan = (&op_b[W-2 -: EXP_W]) & (|op_b[FRAC_W-1:0]) & ~op_b[FRAC_W-1];
    assign a_quiet   = (&op_a[W-2 -: EXP_W]) & op_a[FRAC_W-1];
    assign b_quiet   = (&op_b[W-2 -: EXP_W]) & op_b[FRAC_W-1];
    assign p_nan     = (&prod[W-2 -: EXP_W]) & (|prod[FRAC_W-1:0]);
    assign p_inf     = (&prod[W-2 -: EXP_W]) & ~(|prod[FRAC_W-1:0]);
    assign p_expz    = ~|prod[W-2 -: EXP_W];

    a_r3_snan_raises_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (a_sig_nan || b_sig_nan) |=> exc_invalid);

    a_r4_invalid_gives_nan: assert property (@(posedge clk) disable iff (!rst_n)
        exc_invalid |-> p_nan);

    a_r5_quiet_nan_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_quiet || b_quiet) && !a_sig_nan && !b_sig_nan) |=> (p_nan && !exc_invalid));

    a_r6_overflow_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
        exc_overflow |-> p_inf);

    a_r7_underflow_tiny: assert property (@(posedge clk) disable iff (!rst_n)
        exc_underflow |-> p_expz);

    a_r8_flags_imply_inexact: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_overflow || exc_underflow) |-> exc_inexact);

    a_r9_no_divzero: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_divzero);

endmodule

bind fp_mul_exc fp_mul_exc_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (.*);

// File: tb/fp_mul_exc_tb.sv
`timescale 1ns/1ps
module fp_mul_exc_tb;
    localparam int EW = 8;
    localparam int SW = 24;
    localparam int W  = EW + SW;
    localparam int N  = 22;

    // Fields: [108:101] requirement number, [100:69] a, [68:37] b, [36:5] product,
    // [4:0] flags {invalid, divzero, overflow, underflow, inexact}.
    localparam logic [108:0] VEC [N] = '{
        {8'd2,  32'h3F800000, 32'h3F800000, 32'h3F800000, 5'b00000}, // R2 1*1
        {8'd2,  32'h40000000, 32'h40400000, 32'h40C00000, 5'b00000}, // R2 2*3
        {8'd2,  32'hBFC00000, 32'h40000000, 32'hC0400000, 5'b00000}, // R2 sign
        {8'd8,  32'h3F7FFFFF, 32'h3F7FFFFF, 32'h3F7FFFFE, 5'b00001}, // R8 inexact
        {8'd11, 32'h3F800001, 32'h3FFFFFFE, 32'h40000000, 5'b00001}, // R11 carry
        {8'd6,  32'h7F7FFFFF, 32'h40000000, 32'h7F800000, 5'b00101}, // R6 overflow
        {8'd11, 32'h7F000001, 32'h3FFFFFFE, 32'h7F800000, 5'b00101}, // R11 carry to inf
        {8'd6,  32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 5'b00000}, // R6 max exact
        {8'd4,  32'h7F800000, 32'h00000000, 32'h7FC00000, 5'b10000}, // R4 inf*0
        {8'd10, 32'hFF800000, 32'h40000000, 32'hFF800000, 5'b00000}, // R10 inf*2
        {8'd10, 32'h80000000, 32'h40A00000, 32'h80000000, 5'b00000}, // R10 -0*5
        {8'd5,  32'h7FC00001, 32'h3F800000, 32'h7FC00000, 5'b00000}, // R5 qnan
        {8'd3,  32'h7F800001, 32'h3F800000, 32'h7FC00000, 5'b10000}, // R3 snan a
        {8'd3,  32'h3F800000, 32'hFF800001, 32'h7FC00000, 5'b10000}, // R3 snan b
        {8'd3,  32'h7FC00000, 32'h7F800001, 32'h7FC00000, 5'b10000}, // R3 mixed
        {8'd7,  32'h00800000, 32'h3F000000, 32'h00400000, 5'b00000}, // R7 exact tiny
        {8'd7,  32'h00800001, 32'h3F000000, 32'h00400000, 5'b00011}, // R7 tie tiny
        {8'd7,  32'h00000001, 32'h3F000000, 32'h00000000, 5'b00011}, // R7 to zero
        {8'd7,  32'h80000001, 32'h00000001, 32'h80000000, 5'b00011}, // R7 neg zero
        {8'd7,  32'h00FFFFFF, 32'h3F000000, 32'h00800000, 5'b00001}, // R7 up to normal
        {8'd10, 32'h7F800000, 32'h80000001, 32'hFF800000, 5'b00000}, // R10 inf*sub
        {8'd4,  32'h00000000, 32'hFF800000, 32'h7FC00000, 5'b10000}  // R4 0*inf
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = 32'h40000000;
    logic [W-1:0] op_b = 32'h40400000;
    logic [W-1:0] prod;
    logic         exc_invalid, exc_divzero, exc_overflow, exc_underflow, exc_inexact;
    int           n_tests = 0;
    int           n_fail  = 0;
    bit           done    = 1'b0;

    always #4 clk = ~clk;

    fp_mul_exc #(.EXP_W(EW), .SIG_W(SW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_a          (op_a),
        .op_b          (op_b),
        .prod          (prod),
        .exc_invalid   (exc_invalid),
        .exc_divzero   (exc_divzero),
        .exc_overflow  (exc_overflow),
        .exc_underflow (exc_underflow),
        .exc_inexact   (exc_inexact)
    );

    task automatic check(input int req, input logic [W-1:0] exp_o, input logic [4:0] exp_f);
        logic [4:0] got_f;
        got_f = {exc_invalid, exc_divzero, exc_overflow, exc_underflow, exc_inexact};
        n_tests++;
        if (prod !== exp_o || got_f !== exp_f) begin
            n_fail++;
            $display("FAIL R%0d: got %h flags %b, expected %h flags %b",
                     req, prod, got_f, exp_o, exp_f);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        // R1: outputs are zero while reset is held, despite live operands.
        repeat (3) @(negedge clk);
        check(1, 32'h0, 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 32'h40C00000, 5'b00000); // R1 first registered product

        for (int i = 0; i < N; i++) begin
            op_a = VEC[i][100:69];
            op_b = VEC[i][68:37];
            @(negedge clk);
            check(int'(VEC[i][108:101]), VEC[i][36:5], VEC[i][4:0]);
        end

        // R1: a new operand pair does not reach the output before the next edge.
        op_a = 32'h40000000;
        op_b = 32'h40000000;
        @(negedge clk);
        check(1, 32'h40800000, 5'b00000);
        op_a = 32'h7F800000;
        op_b = 32'h00000000;
        #1;
        check(1, 32'h40800000, 5'b00000);
        @(negedge clk);
        check(4, 32'h7FC00000, 5'b10000);

        // R1: asynchronous reset clears a held result mid-run.
        rst_n = 1'b0;
        #1;
        check(1, 32'h0, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;
        op_a = 32'hC0000000;
        op_b = 32'h00000000;
        @(negedge clk);
        check(10, 32'h80000000, 5'b00000); // R10 signed zero after reset
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1: watchdog expired, got no completion, expected completion");
        finish_run();
    end

endmodule